// File: doc/BRIEF.md
# Two-Level Hardware Return Stack

This block holds return addresses for a small processor core that has no memory-based stack. It keeps two 12-bit return slots, a top slot and a bottom slot, and changes them only on call and return events. On a call the top slot moves down into the bottom slot, and the supplied return address is written into the top slot. On a return the core reads the top slot, and the bottom slot is copied up into the top slot.

The stack has no pointer and raises no flags. A third call in a row loses the oldest address. A pop past the bottom does not clear anything, because the bottom slot is duplicated upward rather than emptied. Every further pop therefore returns the same address. The top slot is shown combinationally on `stackTop`, so the program counter can take it in the same cycle that the pop strobe is high.

Top module: `retStack`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets both slots to zero, so `stackTop` reads 0 in the cycle after reset.
- R2: `stackTop` always equals the top slot and responds combinationally, with no register between the slot and the port.
- R3: A push (`pushEn` high at a rising edge) writes `pushAddr` into the top slot and the old top slot into the bottom slot.
- R4: A pop (`popEn` high with `pushEn` low at a rising edge) copies the bottom slot into the top slot and leaves the bottom slot unchanged.
- R5: After three or more pushes in a row, only the two most recent addresses can be recovered; the first pop yields the newest address and the second pop yields the one before it.
- R6: After the stack has been emptied, every further pop keeps showing the value that was last in the bottom slot.
- R7: When `pushEn` and `popEn` are both high in the same cycle, the push takes effect and the pop is ignored.
- R8: With neither strobe high, both slots hold their values.
- R9: The block has no overflow or underflow output; its only output is `stackTop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pushEn | input | 1 | Call strobe; `pushAddr` is stored when this is high |
| pushAddr | input | 12 | Return address written on a push |
| popEn | input | 1 | Return strobe |
| stackTop | output | 12 | Current top slot, driven combinationally |

## Verification
A corrupted top slot shows on `stackTop` at once, in the cycle after the bad edge. A corrupted bottom slot stays hidden until a pop lifts it, so it only shows in the cycle after the next pop. For that reason the bench keeps the depth of push/pop runs short, and drains the stack often through repeated pops, so that the bottom slot is brought out quickly. Repeated pops past empty make a wrong hold of the bottom slot visible on every later read.

// File: rtl/retStackPkg.sv
package retStackPkg;
  typedef struct packed {
    logic clear;
    logic shiftDown;
    logic shiftUp;
  } stackCtl_t;
endpackage

// File: rtl/retStackCtl.sv
module retStackCtl
  import retStackPkg::*;
(
  input  logic      rst,
  input  logic      pushEn,
  input  logic      popEn,
  output stackCtl_t ctl
);
  always_comb begin
    ctl = '0;
    if (rst)         ctl.clear     = 1'b1;
    else if (pushEn) ctl.shiftDown = 1'b1;
    else if (popEn)  ctl.shiftUp   = 1'b1;
  end
endmodule

// File: rtl/retStackData.sv
module retStackData
  import retStackPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEVELS = 2
) (
  input  logic              clk,
  input  stackCtl_t         ctl,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic [ADDR_W-1:0] topOut
);
  localparam int LAST = LEVELS - 1;
  logic [ADDR_W-1:0] slot [LEVELS];

  generate
    for (genvar i = 0; i < LEVELS; i++) begin : g_slot
      logic [ADDR_W-1:0] downVal;
      logic [ADDR_W-1:0] upVal;
      if (i == 0) begin : g_first
        assign downVal = pushAddr;
      end else begin : g_rest
        assign downVal = slot[i-1];
      end
      if (i == LAST) begin : g_last
        assign upVal = slot[i];
      end else begin : g_inner
        assign upVal = slot[i+1];
      end
      always_ff @(posedge clk) begin
        if (ctl.clear)          slot[i] <= '0;
        else if (ctl.shiftDown) slot[i] <= downVal;
        else if (ctl.shiftUp)   slot[i] <= upVal;
      end
    end
  endgenerate

  assign topOut = slot[0];
endmodule

// File: rtl/retStack.sv
module retStack
  import retStackPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEVELS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushEn,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              popEn,
  output logic [ADDR_W-1:0] stackTop
);
  stackCtl_t ctl;

  retStackCtl ctl_i (.rst(rst), .pushEn(pushEn), .popEn(popEn), .ctl(ctl));

  retStackData #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) data_i (
    .clk(clk), .ctl(ctl), .pushAddr(pushAddr), .topOut(stackTop)
  );
endmodule

// File: rtl/retStackChk.sv
module retStackChk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              pushEn,
  input logic [ADDR_W-1:0] pushAddr,
  input logic              popEn,
  input logic [ADDR_W-1:0] stackTop
);
  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> stackTop == '0); // R1
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst || !seenReset)
    pushEn |=> stackTop == $past(pushAddr)); // R3 R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!pushEn && !popEn) |=> $stable(stackTop)); // R8
  AST_POP_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (pushEn ##1 (popEn && !pushEn)) |=> stackTop == $past(stackTop, 2)); // R4
  AST_DOUBLE_POP: assert property (@(posedge clk) disable iff (rst || !seenReset)
    ((popEn && !pushEn) ##1 (popEn && !pushEn)) |=> $stable(stackTop)); // R6
endmodule

bind retStack retStackChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .pushEn(pushEn), .pushAddr(pushAddr),
  .popEn(popEn), .stackTop(stackTop)
);

// File: tb/retStack_tb_top.sv
module retStack_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pushEn = 1'b0;
  logic popEn = 1'b0;
  logic [11:0] pushAddr = '0;
  logic [11:0] stackTop;
  int total = 0;
  int bad = 0;
  logic [11:0] mTop = '0;
  logic [11:0] mBot = '0;

  always #2.5 clk = ~clk;

  retStack dut_i (.clk(clk), .rst(rst), .pushEn(pushEn), .pushAddr(pushAddr),
                  .popEn(popEn), .stackTop(stackTop));

  function automatic logic [23:0] modelStep(logic [11:0] t, logic [11:0] b,
                                            logic pu, logic po, logic [11:0] a);
    if (pu) return {a, t};
    if (po) return {b, b};
    return {t, b};
  endfunction

  task automatic check(string req, logic [11:0] exp);
    total++;
    if (stackTop !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, stackTop, exp);
    end
  endtask

  task automatic step(logic pu, logic po, logic [11:0] a);
    logic [23:0] n;
    pushEn = pu; popEn = po; pushAddr = a;
    @(posedge clk);
    n = modelStep(mTop, mBot, pu, po, a);
    mTop = n[23:12]; mBot = n[11:0];
    #1;
    pushEn = 0; popEn = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    check("R1", 12'h000);
    step(1, 0, 12'h111); check("R3 R2", 12'h111);
    step(1, 0, 12'h222); check("R3", 12'h222);
    step(0, 0, 12'hfff); check("R8", 12'h222);
    step(1, 0, 12'h333); check("R5", 12'h333);
    step(0, 1, 12'h0);   check("R5", 12'h222);
    step(0, 1, 12'h0);   check("R4 R5", 12'h222);
    step(0, 1, 12'h0);   check("R6", 12'h222);
    step(0, 1, 12'h0);   check("R6", 12'h222);
    step(1, 1, 12'h444); check("R7", 12'h444);
    step(0, 1, 12'h0);   check("R7 R4", 12'h222);
    step(1, 0, 12'h555); step(1, 0, 12'h666);
    step(0, 1, 12'h0);   check("R4", 12'h555);
    step(0, 1, 12'h0);   check("R6", 12'h555);
    // R2: combinational visibility mid-cycle
    #1; check("R2", 12'h555);
    for (int i = 0; i < 400; i++) begin
      logic r;
      r = ($urandom % 3) == 0;
      step(($urandom % 3) == 0, ($urandom % 2) == 0, 12'($urandom));
      check("R3 R4 R8 random", mTop);
      if (r && (i % 50 == 0)) begin
        rst = 1; @(posedge clk); #1; rst = 0;
        mTop = '0; mBot = '0;
        check("R1", 12'h000);
      end
    end
    // R9: only output is stackTop, checked structurally by port list
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule